// File: doc/BRIEF.md
# Pixel Frame Capture Controller for Asynchronous SRAM

The controller accepts a slow stream of 16-bit pixel samples and stores a full frame in an external asynchronous SRAM. A synchronous start clears both pointers and opens a capture phase. Each accepted sample takes two consecutive words: the sample value at an even address and its pixel number at the odd address after it. Once the top address has been written, the block turns round on its own and reads the whole memory back from address zero. Each word goes to the host with a valid/ready handshake.

Every memory access lasts exactly four system clocks and is tracked by a two-bit phase count. The address is loaded when the access starts and is held for all four phases. A write drives the data bus for phases 1 to 3 and pulls the write strobe low only in phases 1 and 2. A read pulls the output enable low for phases 1 to 3 and latches the bus at the end of phase 3. The bus is released between accesses, so ownership never overlaps. A one-entry holding register absorbs a sample that arrives while a two-word store is running. A sample that arrives while that register is still occupied is discarded and raises a sticky overrun flag.

Top module: `frame_sram_ctrl`

## Requirements
- R1: After reset, and in the idle state, the write strobe and output enable are both high (inactive), `rdValid`, `captureDone`, `readoutDone` and `overrun` are 0, and a sample offered in the idle state causes no write.
- R2: After `start`, the k-th accepted sample (k from 0) is written at address 2k and the value k (zero-extended address/2) is written at address 2k+1.
- R3: Every access lasts four clocks. The address is held for the whole access. Each write strobe low pulse is exactly two clocks long and falls inside the window in which the block drives the bus.
- R4: The block drives the data bus only during write phases 1 to 3. Output enable is never low while the block drives the bus, and the write strobe and output enable are never low together.
- R5: A sample that arrives while a store is in progress is kept in the holding register and stored in arrival order once the store completes.
- R6: A sample that arrives while the holding register is occupied and not being emptied is dropped, and `overrun` goes to 1 and stays at 1 until the next `start`.
- R7: `captureDone` rises once the word at the highest address has been written. After that, samples are ignored: no further writes occur and `overrun` does not change.
- R8: Readout delivers every address from 0 upward in order on `rdData` with `rdValid` high. `rdValid` and `rdData` hold steady while `rdReady` is low, and no new read (output enable low) starts until the word has been accepted.
- R9: `readoutDone` rises on the clock where the word at the highest address is accepted. No further access happens after that.
- R10: `start` in any state aborts the current activity, clears both pointers, `rdValid`, `overrun`, `captureDone` and `readoutDone`, and begins a new capture at address 0.
- R11: Each read holds output enable low for exactly three consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Clears pointers and flags and opens a new capture |
| sampleValid | input | 1 | One-clock pulse marking a new pixel sample |
| sampleData | input | DATA_W | Pixel sample value |
| sramAddr | output | ADDR_W | SRAM word address |
| sramWeN | output | 1 | SRAM write strobe, active low |
| sramOeN | output | 1 | SRAM output enable, active low |
| sramData | inout | DATA_W | Shared SRAM data bus, released when not writing |
| rdData | output | DATA_W | Word read back during readout |
| rdValid | output | 1 | `rdData` holds a word not yet accepted |
| rdReady | input | 1 | Host accepts the current word |
| overrun | output | 1 | Sticky: a sample was dropped |
| captureDone | output | 1 | Whole memory has been written |
| readoutDone | output | 1 | Whole memory has been read out |

## Verification
The bench runs a 16-word memory through three full captures. One has relaxed sample spacing, one has the tightest spacing the store time allows, and one packs three samples so close together that the third must be dropped. Each capture is checked word by word against a behavioural SRAM. If the design wrote the pixel number to the wrong address or dropped the held sample, the stored pairs would come back shifted. If it mishandled the full holding register, either the pairs would be overwritten or the overrun flag would stay low. A monitor measures the width of every strobe and output-enable pulse and any overlap between them, so an off-by-one in the phase decode or a read that starts while a word is still waiting is caught. The bench also restarts in the middle of a readout, pulses samples after capture has ended, and stalls the host for varying lengths to show that the flags clear, that late samples are ignored and that held words stay stable.

// File: rtl/fcap_pkg.sv
`timescale 1ns/1ps
package fcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CAPTURE = 2'd1,
    ST_READOUT = 2'd2,
    ST_DONE    = 2'd3
  } fcapState_t;

  typedef enum logic [1:0] {
    ACC_WVAL = 2'd0,
    ACC_WIDX = 2'd1,
    ACC_READ = 2'd2
  } fcapAccess_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic clearAll;   // synchronous restart
    logic acceptEn;   // samples may enter the holding register
    logic loadValue;  // move held sample into the write register
    logic loadIndex;  // load pixel number into the write register
    logic busDrive;   // drive the shared data bus
    logic latchRead;  // capture the bus into the readout register
  } fcapStrobes_t;
endpackage

// File: rtl/fcap_ctrl.sv
`timescale 1ns/1ps
module fcap_ctrl
  import fcap_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              holdFull,
  input  logic              rdReady,
  output fcapStrobes_t      strobes,
  output logic [ADDR_W-1:0] accessAddr,
  output logic              sramWeN,
  output logic              sramOeN,
  output logic              rdValid,
  output logic              captureDone,
  output logic              readoutDone
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] LAST_PAIR = LAST_ADDR - {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [ADDR_W-1:0] PAIR_STEP = {{(ADDR_W-2){1'b0}}, 2'b10};

  fcapState_t        state;
  fcapAccess_t       kind;
  logic              busy;
  logic [1:0]        phase;
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;

  logic accEnd, wrStart, rdStart, handshake, isWrite;

  always_comb begin
    accEnd    = busy && (phase == 2'd3);
    wrStart   = (state == ST_CAPTURE) && !busy && holdFull;
    rdStart   = (state == ST_READOUT) && !busy && !rdValid;
    handshake = rdValid && rdReady;
    isWrite   = (kind != ACC_READ);

    strobes.clearAll  = start;
    strobes.acceptEn  = (state == ST_CAPTURE) && !start;
    strobes.loadValue = wrStart && !start;
    strobes.loadIndex = accEnd && (kind == ACC_WVAL) && !start;
    strobes.busDrive  = busy && isWrite && (phase != 2'd0);
    strobes.latchRead = accEnd && (kind == ACC_READ) && !start;

    sramWeN = !(busy && isWrite && (phase[0] ^ phase[1]));
    sramOeN = !(busy && !isWrite && (phase != 2'd0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      kind        <= ACC_WVAL;
      busy        <= 1'b0;
      phase       <= 2'd0;
      wrPtr       <= '0;
      rdPtr       <= '0;
      accessAddr  <= '0;
      rdValid     <= 1'b0;
      captureDone <= 1'b0;
      readoutDone <= 1'b0;
    end else if (start) begin
      state       <= ST_CAPTURE;
      kind        <= ACC_WVAL;
      busy        <= 1'b0;
      phase       <= 2'd0;
      wrPtr       <= '0;
      rdPtr       <= '0;
      accessAddr  <= '0;
      rdValid     <= 1'b0;
      captureDone <= 1'b0;
      readoutDone <= 1'b0;
    end else begin
      if (busy) begin
        phase <= phase + 2'd1;
        if (accEnd) begin
          unique case (kind)
            ACC_WVAL: begin
              kind       <= ACC_WIDX;
              accessAddr <= accessAddr + {{(ADDR_W-1){1'b0}}, 1'b1};
            end
            ACC_WIDX: begin
              busy  <= 1'b0;
              wrPtr <= wrPtr + PAIR_STEP;
              if (wrPtr == LAST_PAIR) begin
                captureDone <= 1'b1;
                state       <= ST_READOUT;
              end
            end
            default: begin
              busy    <= 1'b0;
              rdValid <= 1'b1;
            end
          endcase
        end
      end else if (wrStart) begin
        busy       <= 1'b1;
        phase      <= 2'd0;
        kind       <= ACC_WVAL;
        accessAddr <= wrPtr;
      end else if (rdStart) begin
        busy       <= 1'b1;
        phase      <= 2'd0;
        kind       <= ACC_READ;
        accessAddr <= rdPtr;
      end

      if (handshake) begin
        rdValid <= 1'b0;
        if (rdPtr == LAST_ADDR) begin
          readoutDone <= 1'b1;
          state       <= ST_DONE;
        end else begin
          rdPtr <= rdPtr + {{(ADDR_W-1){1'b0}}, 1'b1};
        end
      end
    end
  end

  // R3: the address does not move inside an access
  p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && phase != 2'd0) |-> $stable(accessAddr));

  // R3: a strobe low pulse lasts at least two clocks
  p_we_min_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sramWeN && $past(sramWeN) && !start) |=> !sramWeN);

  // R3: and no more than two
  p_we_max_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sramWeN && $past(!sramWeN)) |=> sramWeN);

  // R8: no read while a word waits for the host
  p_no_read_while_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> sramOeN);

  // R9: silence once readout is complete
  p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    readoutDone |-> (sramOeN && sramWeN && !busy));
endmodule

// File: rtl/fcap_datapath.sv
`timescale 1ns/1ps
module fcap_datapath
  import fcap_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fcapStrobes_t      strobes,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [ADDR_W-1:0] accessAddr,
  inout  wire  [DATA_W-1:0] sramData,
  output logic              holdFull,
  output logic              overrun,
  output logic [DATA_W-1:0] rdData
);
  localparam int WIDE_W = ADDR_W + DATA_W;

  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] wrData;
  logic              canLoad;

  // pixel number of the pair whose value word sits at addr
  function automatic logic [DATA_W-1:0] pixelWord(input logic [ADDR_W-1:0] addr);
    logic [WIDE_W-1:0] wide;
    wide = {{DATA_W{1'b0}}, addr} >> 1;
    return wide[DATA_W-1:0];
  endfunction

  assign canLoad  = !holdFull || strobes.loadValue;
  assign sramData = strobes.busDrive ? wrData : {DATA_W{1'bz}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      overrun  <= 1'b0;
    end else if (strobes.clearAll) begin
      holdFull <= 1'b0;
      overrun  <= 1'b0;
    end else if (strobes.acceptEn && sampleValid) begin
      if (canLoad) begin
        holdReg  <= sampleData;
        holdFull <= 1'b1;
      end else begin
        overrun <= 1'b1;
      end
    end else if (strobes.loadValue) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wrData <= '0;
    end else if (strobes.loadValue) begin
      wrData <= holdReg;
    end else if (strobes.loadIndex) begin
      wrData <= pixelWord(accessAddr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData <= '0;
    end else if (strobes.latchRead) begin
      rdData <= sramData;
    end
  end

  // R6: overrun stays set until a restart
  p_overrun_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !strobes.clearAll) |=> overrun);

  // R5: an occupied register is only emptied by a store start or a restart
  p_hold_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (holdFull && !strobes.loadValue && !strobes.clearAll) |=> holdFull);
endmodule

// File: rtl/frame_sram_ctrl.sv
`timescale 1ns/1ps
module frame_sram_ctrl
  import fcap_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  output logic [ADDR_W-1:0] sramAddr,
  output logic              sramWeN,
  output logic              sramOeN,
  inout  wire  [DATA_W-1:0] sramData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              overrun,
  output logic              captureDone,
  output logic              readoutDone
);
  fcapStrobes_t strobes;
  logic         holdFull;

  fcap_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .holdFull   (holdFull),
    .rdReady    (rdReady),
    .strobes    (strobes),
    .accessAddr (sramAddr),
    .sramWeN    (sramWeN),
    .sramOeN    (sramOeN),
    .rdValid    (rdValid),
    .captureDone(captureDone),
    .readoutDone(readoutDone)
  );

  fcap_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .accessAddr (sramAddr),
    .sramData   (sramData),
    .holdFull   (holdFull),
    .overrun    (overrun),
    .rdData     (rdData)
  );

  // R4: the memory never drives while the block drives
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sramOeN |-> !strobes.busDrive);

  // R4: strobe and output enable never overlap
  p_we_oe_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sramWeN && !sramOeN));

  // R8: a pending word holds until accepted
  p_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdValid && !rdReady && !start) |=> (rdValid && $stable(rdData)));

  // R7: no writes once the frame is complete
  p_no_write_after_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    captureDone |-> sramWeN);
endmodule

// File: tb/frame_sram_ctrl_tb.sv
`timescale 1ns/1ps
module frame_sram_ctrl_tb_top;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int WORDS  = 1 << ADDR_W;
  localparam int PAIRS  = WORDS / 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              sampleValid = 1'b0;
  logic [DATA_W-1:0] sampleData = '0;
  logic              rdReady = 1'b0;
  logic [ADDR_W-1:0] sramAddr;
  logic              sramWeN, sramOeN;
  wire  [DATA_W-1:0] sramData;
  logic [DATA_W-1:0] rdData;
  logic              rdValid, overrun, captureDone, readoutDone;

  always #10 clk = ~clk;

  frame_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sampleValid(sampleValid),
    .sampleData(sampleData), .sramAddr(sramAddr), .sramWeN(sramWeN),
    .sramOeN(sramOeN), .sramData(sramData), .rdData(rdData), .rdValid(rdValid),
    .rdReady(rdReady), .overrun(overrun), .captureDone(captureDone),
    .readoutDone(readoutDone)
  );

  // behavioural asynchronous SRAM
  logic [DATA_W-1:0] mem [WORDS];
  initial for (int i = 0; i < WORDS; i++) mem[i] = '0;
  always @(posedge sramWeN) mem[sramAddr] <= sramData;
  assign sramData = !sramOeN ? mem[sramAddr] : {DATA_W{1'bz}};

  // pin monitor
  int weRun = 0, oeRun = 0, weBad = 0, oeBad = 0, overlapBad = 0;
  int weTotal = 0, oeTotal = 0, oeWhileValid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!sramWeN) begin weRun++; weTotal++; end
      else if (weRun != 0) begin if (weRun != 2) weBad++; weRun = 0; end
      if (!sramOeN) begin oeRun++; oeTotal++; end
      else if (oeRun != 0) begin if (oeRun != 3) oeBad++; oeRun = 0; end
      if (!sramWeN && !sramOeN) overlapBad++;
      if (rdValid && !sramOeN) oeWhileValid++;
    end
  end

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] expMem [WORDS];
  bit timedOut = 1'b0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic sendSample(input logic [DATA_W-1:0] v);
    sampleValid = 1'b1; sampleData = v;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // relaxed or tight capture: PAIRS samples, gap clocks apart
  task automatic doCapture(input logic [DATA_W-1:0] base, input int gap);
    for (int k = 0; k < PAIRS; k++) begin
      logic [DATA_W-1:0] v;
      v = base + DATA_W'(k * 13);
      expMem[2*k]   = v;
      expMem[2*k+1] = DATA_W'(k);
      sendSample(v);
      repeat (gap - 1) @(negedge clk);
    end
    while (!captureDone) @(negedge clk);
  endtask

  task automatic checkMem(input string tag);
    for (int a = 0; a < WORDS; a++)
      chk(mem[a] == expMem[a], tag, 32'(mem[a]), 32'(expMem[a]));
  endtask

  task automatic doReadout(input int nWords, input bit inject);
    for (int w = 0; w < nWords; w++) begin
      while (!rdValid) @(negedge clk);
      chk(rdData == expMem[w], "R8 readout word", 32'(rdData), 32'(expMem[w]));
      for (int s = 0; s < (w % 3); s++) begin
        logic [DATA_W-1:0] held;
        held = rdData;
        @(negedge clk);
        chk(rdValid && rdData == held, "R8 word held while not ready",
            32'(rdData), 32'(held));
      end
      if (inject && w == 5) sendSample(16'hDEAD);
      rdReady = 1'b1;
      @(negedge clk);
      rdReady = 1'b0;
    end
  endtask

  task automatic runAll();
    int snapWe, snapOe;
    // R1: reset and idle
    repeat (3) @(negedge clk);
    chk(sramWeN && sramOeN, "R1 strobes inactive in reset", {sramWeN, sramOeN}, 2'b11);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rdValid, captureDone, readoutDone, overrun} == 4'b0, "R1 flags clear",
        {rdValid, captureDone, readoutDone, overrun}, 0);
    snapWe = weTotal;
    sendSample(16'h1234);
    repeat (12) @(negedge clk);
    chk(weTotal == snapWe, "R1 idle sample ignored", weTotal - snapWe, 0);

    // pattern 1: relaxed spacing
    pulseStart();
    snapWe = weTotal;
    doCapture(16'hA000, 12);
    checkMem("R2 stored pairs relaxed");
    chk(weTotal - snapWe == 2 * WORDS, "R3 strobe clocks per frame",
        weTotal - snapWe, 2 * WORDS);
    chk(overrun == 1'b0, "R6 no overrun relaxed", overrun, 0);
    snapWe = weTotal; snapOe = oeTotal;
    doReadout(WORDS, 1'b1);
    @(negedge clk);
    chk(readoutDone == 1'b1, "R9 readout done", readoutDone, 1);
    chk(weTotal == snapWe, "R7 late sample not written", weTotal - snapWe, 0);
    chk(overrun == 1'b0, "R7 late sample no overrun", overrun, 0);
    chk(oeTotal - snapOe == 3 * WORDS, "R11 enable clocks per frame",
        oeTotal - snapOe, 3 * WORDS);
    snapOe = oeTotal;
    repeat (20) @(negedge clk);
    chk(oeTotal == snapOe && sramWeN, "R9 no access after done", oeTotal - snapOe, 0);

    // pattern 2: collision and overrun
    pulseStart();
    chk({captureDone, readoutDone} == 2'b00, "R10 flags cleared by start",
        {captureDone, readoutDone}, 0);
    sendSample(16'h1111);          // A
    @(negedge clk);
    sendSample(16'h2222);          // B, arrives during A's store
    @(negedge clk);
    sendSample(16'h3333);          // C, register full: dropped
    chk(overrun == 1'b1, "R6 overrun raised", overrun, 1);
    repeat (20) @(negedge clk);
    expMem[0] = 16'h1111; expMem[1] = 0;
    expMem[2] = 16'h2222; expMem[3] = 1;
    for (int k = 2; k < PAIRS; k++) begin
      expMem[2*k]   = 16'h5000 + DATA_W'(k);
      expMem[2*k+1] = DATA_W'(k);
      sendSample(expMem[2*k]);
      repeat (11) @(negedge clk);
    end
    while (!captureDone) @(negedge clk);
    checkMem("R5 held sample stored in order");
    chk(overrun == 1'b1, "R6 overrun sticky", overrun, 1);
    doReadout(3, 1'b0);

    // restart during readout
    start = 1'b1; @(negedge clk); start = 1'b0;
    chk({rdValid, overrun, captureDone, readoutDone} == 4'b0,
        "R10 restart clears state", {rdValid, overrun, captureDone, readoutDone}, 0);
    @(negedge clk);
    chk(sramOeN && sramWeN, "R10 bus idle after restart", {sramWeN, sramOeN}, 2'b11);

    // pattern 3: tightest spacing without overrun
    doCapture(16'h0F00, 9);
    checkMem("R2 stored pairs tight");
    chk(overrun == 1'b0, "R5 tight spacing no overrun", overrun, 0);
    doReadout(WORDS, 1'b0);
    @(negedge clk);
    chk(readoutDone == 1'b1, "R9 readout done after restart", readoutDone, 1);

    // pin timing collected by the monitor
    chk(weBad == 0, "R3 strobe pulse width", weBad, 0);
    chk(oeBad == 0, "R11 enable pulse width", oeBad, 0);
    chk(overlapBad == 0, "R4 strobe and enable overlap", overlapBad, 0);
    chk(oeWhileValid == 0, "R8 read while word pending", oeWhileValid, 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (100000) @(posedge clk);
        timedOut = 1'b1;
      end
    join_any
    if (timedOut) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule